// File: doc/BRIEF.md
# Memory-mapped I/O access splitter

This block sits between a load/store pipeline and a memory-mapped I/O bus. It takes one request at a time. Each request carries a physical address, a byte count from 1 to 8, a direction flag and store data. A request whose byte count is a power of two and whose address is a multiple of that count goes out as one bus transfer of the full width. Any other legal request is broken into single-byte transfers. These start at the base address and rise by one byte each. Devices behind the bus therefore only ever see naturally aligned, power-of-two sized accesses.

Before each transfer is issued, the block asks a combinational permission port about that transfer's address and direction. The first refusal ends the request. So does the first bus error response. When a request ends this way the block issues nothing more and reports a fault. Bytes already stored stay stored. For loads, the block gathers the returned bytes into a little-endian result. A one-cycle completion pulse carries the result and a fault flag.

The bus side allows one transfer outstanding. After each transfer the block waits for its response before it issues the next one.

Top module: `mmio_split_unit`

## Requirements
- R1: While reset is asserted and after it is released, `req_ready` is 1 and both `bus_valid` and `done_valid` are 0 until a request arrives.
- R2: A request whose length is 1, 2, 4 or 8 and whose address is a multiple of that length produces exactly one bus transfer. That transfer is at the request address with `bus_size` = log2(length) (1→0, 2→1, 4→2, 8→3). For a store, `bus_wdata` equals `req_wdata` unchanged.
- R3: Any other request with a length from 1 to 8 produces up to `length` transfers with `bus_size` = 0. Transfer i is at address base+i, with i rising from 0. For a store, transfer i carries byte i of `req_wdata` (bits 8i+7..8i) on `bus_wdata[7:0]`, with all other bits 0.
- R4: `perm_addr` and `perm_write` present the transfer about to be issued. A transfer is issued only in a cycle where `perm_ok` is 1. A refused transfer is not issued, no later transfer follows, and the request completes with `done_fault` = 1.
- R5: A response with `bus_resp_err` = 1 ends the request. No further transfer is issued, and `done_valid` with `done_fault` = 1 follows in the next cycle.
- R6: A store that fails part way is not undone: the bytes whose transfers completed without error remain written.
- R7: A length of 0 or greater than 8 is rejected without any bus transfer. `done_valid` with `done_fault` = 1 appears in the cycle right after acceptance.
- R8: A load that succeeds returns byte i of the access in `done_rdata[8i+7:8i]`. For a whole transfer, byte i is taken from lane i of `bus_rdata`. For a split access, it is taken from `bus_rdata[7:0]` of transfer i. All bytes at or above the length read 0.
- R9: At most one bus transfer is outstanding: no `bus_valid` appears between a transfer and its response. `req_ready` is 0 from acceptance until after completion.
- R10: `done_valid` is a single-cycle pulse. Loads and stores follow the same splitting and checking rules.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised inside |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and accepting a request |
| req_addr | input | ADDR_W | Physical byte address |
| req_len | input | LEN_W | Byte count (legal 1 to MAX_BYTES) |
| req_write | input | 1 | 1 = store, 0 = load |
| req_wdata | input | DATA_W | Store data, little-endian |
| done_valid | output | 1 | One-cycle completion pulse |
| done_fault | output | 1 | Request failed (reject, refusal or bus error) |
| done_rdata | output | DATA_W | Load result, little-endian, zero above length |
| perm_addr | output | ADDR_W | Address of the transfer being checked |
| perm_write | output | 1 | Direction of the transfer being checked |
| perm_ok | input | 1 | Combinational permission answer |
| bus_valid | output | 1 | Transfer issued this cycle |
| bus_addr | output | ADDR_W | Transfer address |
| bus_size | output | SIZE_W | log2 of transfer bytes |
| bus_write | output | 1 | Transfer direction |
| bus_wdata | output | DATA_W | Transfer store data |
| bus_resp_valid | input | 1 | Response for the outstanding transfer |
| bus_resp_err | input | 1 | Response reports an error |
| bus_rdata | input | DATA_W | Response load data |

## Verification
The bench builds the block with its default parameters: a 32-bit address and an 8-byte maximum, which gives a 4-bit length field and a 2-bit size code. With these values all four whole sizes can be reached, as can split accesses that start at every byte offset within a word. Because the 4-bit length field can carry values from 9 to 15, the out-of-range rejection can be driven through the port as well as the zero length. A bench memory of 256 bytes, a denied address and a faulting address let refusals and errors be placed at the first, a middle or the last byte of a sequence.

// File: rtl/mmio_split_pkg.sv
`timescale 1ns/1ps
package mmio_split_pkg;
  typedef enum logic [1:0] {
    SPL_IDLE  = 2'd0,
    SPL_ISSUE = 2'd1,
    SPL_WAIT  = 2'd2,
    SPL_DONE  = 2'd3
  } spl_state_e;
endpackage

// File: rtl/mmio_split_rstsync.sv
`timescale 1ns/1ps
module mmio_split_rstsync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q     <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      meta_q     <= 1'b1;
      rst_sync_n <= meta_q;
    end
  end
endmodule

// File: rtl/mmio_split_classify.sv
`timescale 1ns/1ps
module mmio_split_classify #(
  parameter int MAX_BYTES = 8,
  parameter int LEN_W     = 4,
  parameter int SIZE_W    = 2
) (
  input  logic [LEN_W-1:0]  addr_lo,
  input  logic [LEN_W-1:0]  len,
  output logic              whole,
  output logic              bad,
  output logic [SIZE_W-1:0] size_code
);
  logic [LEN_W-1:0] len_m1;
  logic             pow2;
  logic             aligned;

  always_comb begin
    len_m1  = len - LEN_W'(1);
    pow2    = (len & len_m1) == '0;
    aligned = (addr_lo & len_m1) == '0;
    bad     = (len == '0) || (len > LEN_W'(MAX_BYTES));
    whole   = pow2 && aligned && !bad;
  end

  // log2 of the length, valid only for whole transfers
  always_comb begin
    size_code = '0;
    for (int k = 0; k < (1 << SIZE_W); k++) begin
      if (len == LEN_W'(1 << k)) size_code = SIZE_W'(k);
    end
  end
endmodule

// File: rtl/mmio_split_seq.sv
`timescale 1ns/1ps
module mmio_split_seq
  import mmio_split_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 4,
  parameter int SIZE_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic              req_write,
  input  logic              cls_whole,
  input  logic              cls_bad,
  input  logic [SIZE_W-1:0] cls_size,
  input  logic              perm_ok,
  input  logic              bus_resp_valid,
  input  logic              bus_resp_err,
  output logic              req_ready,
  output logic              accept,
  output logic              capture,
  output logic              issue,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              write_q,
  output logic              whole_q,
  output logic [LEN_W-1:0]  len_q,
  output logic [LEN_W-1:0]  idx_q,
  output logic [SIZE_W-1:0] xfer_size,
  output logic              done_valid,
  output logic              done_fault
);
  spl_state_e        state_q, state_d;
  logic [ADDR_W-1:0] base_q;
  logic [SIZE_W-1:0] size_q;
  logic [LEN_W-1:0]  idx_d;
  logic              fault_q, fault_d;
  logic              last_byte;

  assign last_byte = (idx_q == (len_q - LEN_W'(1)));

  // next-state process
  always_comb begin
    state_d = state_q;
    fault_d = fault_q;
    idx_d   = idx_q;
    accept  = 1'b0;
    issue   = 1'b0;
    capture = 1'b0;
    unique case (state_q)
      SPL_IDLE: begin
        if (req_valid) begin
          accept  = 1'b1;
          idx_d   = '0;
          fault_d = cls_bad;
          state_d = cls_bad ? SPL_DONE : SPL_ISSUE;
        end
      end
      SPL_ISSUE: begin
        if (perm_ok) begin
          issue   = 1'b1;
          state_d = SPL_WAIT;
        end else begin
          fault_d = 1'b1;
          state_d = SPL_DONE;
        end
      end
      SPL_WAIT: begin
        if (bus_resp_valid) begin
          if (bus_resp_err) begin
            fault_d = 1'b1;
            state_d = SPL_DONE;
          end else begin
            capture = 1'b1;
            if (whole_q || last_byte) begin
              state_d = SPL_DONE;
            end else begin
              idx_d   = idx_q + LEN_W'(1);
              state_d = SPL_ISSUE;
            end
          end
        end
      end
      SPL_DONE: state_d = SPL_IDLE;
      default:  state_d = SPL_IDLE;
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SPL_IDLE;
      fault_q <= 1'b0;
      idx_q   <= '0;
      base_q  <= '0;
      len_q   <= '0;
      write_q <= 1'b0;
      whole_q <= 1'b0;
      size_q  <= '0;
    end else begin
      state_q <= state_d;
      fault_q <= fault_d;
      idx_q   <= idx_d;
      if (accept) begin
        base_q  <= req_addr;
        len_q   <= req_len;
        write_q <= req_write;
        whole_q <= cls_whole;
        size_q  <= cls_size;
      end
    end
  end

  assign cur_addr   = base_q + ADDR_W'(idx_q);
  assign xfer_size  = whole_q ? size_q : '0;
  assign req_ready  = (state_q == SPL_IDLE);
  assign done_valid = (state_q == SPL_DONE);
  assign done_fault = fault_q;
endmodule

// File: rtl/mmio_split_lanes.sv
`timescale 1ns/1ps
module mmio_split_lanes #(
  parameter int MAX_BYTES = 8,
  parameter int LEN_W     = 4,
  parameter int LANE_W    = 3,
  parameter int DATA_W    = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              capture,
  input  logic              whole,
  input  logic [LEN_W-1:0]  len,
  input  logic [LEN_W-1:0]  idx,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] rdata_q
);
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rdata_d;
  logic [7:0]        wbytes [MAX_BYTES];

  for (genvar k = 0; k < MAX_BYTES; k++) begin : g_lane
    assign wbytes[k] = wdata_q[8*k +: 8];
    always_comb begin
      if (whole) begin
        rdata_d[8*k +: 8] = (LEN_W'(k) < len) ? bus_rdata[8*k +: 8] : 8'h00;
      end else if (idx[LANE_W-1:0] == LANE_W'(k)) begin
        rdata_d[8*k +: 8] = bus_rdata[7:0];
      end else begin
        rdata_d[8*k +: 8] = rdata_q[8*k +: 8];
      end
    end
  end

  // a split transfer always drives its byte on the lowest lane
  assign bus_wdata = whole ? wdata_q
                           : {{(DATA_W-8){1'b0}}, wbytes[idx[LANE_W-1:0]]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      if (accept)  wdata_q <= req_wdata;
      if (accept)       rdata_q <= '0;
      else if (capture) rdata_q <= rdata_d;
    end
  end
endmodule

// File: rtl/mmio_split_unit.sv
`timescale 1ns/1ps
module mmio_split_unit #(
  parameter  int ADDR_W    = 32,
  parameter  int MAX_BYTES = 8,
  localparam int LEN_W     = $clog2(MAX_BYTES + 1),
  localparam int LANE_W    = $clog2(MAX_BYTES),
  localparam int SIZE_W    = $clog2(LANE_W + 1),
  localparam int DATA_W    = 8 * MAX_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic              req_write,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              done_valid,
  output logic              done_fault,
  output logic [DATA_W-1:0] done_rdata,
  output logic [ADDR_W-1:0] perm_addr,
  output logic              perm_write,
  input  logic              perm_ok,
  output logic              bus_valid,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [SIZE_W-1:0] bus_size,
  output logic              bus_write,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_resp_valid,
  input  logic              bus_resp_err,
  input  logic [DATA_W-1:0] bus_rdata
);
  logic              rst_sync_n;
  logic              cls_whole, cls_bad;
  logic [SIZE_W-1:0] cls_size;
  logic              accept, capture, issue;
  logic [ADDR_W-1:0] cur_addr;
  logic              write_q, whole_q;
  logic [LEN_W-1:0]  len_q, idx_q;

  mmio_split_rstsync rst_i (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  mmio_split_classify #(
    .MAX_BYTES(MAX_BYTES), .LEN_W(LEN_W), .SIZE_W(SIZE_W)
  ) cls_i (
    .addr_lo(req_addr[LEN_W-1:0]), .len(req_len),
    .whole(cls_whole), .bad(cls_bad), .size_code(cls_size)
  );

  mmio_split_seq #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .SIZE_W(SIZE_W)
  ) seq_i (
    .clk(clk), .rst_n(rst_sync_n),
    .req_valid(req_valid), .req_addr(req_addr), .req_len(req_len),
    .req_write(req_write), .cls_whole(cls_whole), .cls_bad(cls_bad),
    .cls_size(cls_size), .perm_ok(perm_ok),
    .bus_resp_valid(bus_resp_valid), .bus_resp_err(bus_resp_err),
    .req_ready(req_ready), .accept(accept), .capture(capture), .issue(issue),
    .cur_addr(cur_addr), .write_q(write_q), .whole_q(whole_q),
    .len_q(len_q), .idx_q(idx_q), .xfer_size(bus_size),
    .done_valid(done_valid), .done_fault(done_fault)
  );

  mmio_split_lanes #(
    .MAX_BYTES(MAX_BYTES), .LEN_W(LEN_W), .LANE_W(LANE_W), .DATA_W(DATA_W)
  ) lanes_i (
    .clk(clk), .rst_n(rst_sync_n),
    .accept(accept), .capture(capture), .whole(whole_q),
    .len(len_q), .idx(idx_q), .req_wdata(req_wdata), .bus_rdata(bus_rdata),
    .bus_wdata(bus_wdata), .rdata_q(done_rdata)
  );

  assign perm_addr  = cur_addr;
  assign perm_write = write_q;
  assign bus_addr   = cur_addr;
  assign bus_write  = write_q;
  assign bus_valid  = issue;
endmodule

// File: rtl/mmio_split_chk.sv
`timescale 1ns/1ps
module mmio_split_chk #(
  parameter int LEN_W  = 4,
  parameter int LANE_W = 3,
  parameter int SIZE_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [LEN_W-1:0]  req_len,
  input logic              done_valid,
  input logic              done_fault,
  input logic              perm_ok,
  input logic              bus_valid,
  input logic [LANE_W-1:0] bus_addr_lo,
  input logic [SIZE_W-1:0] bus_size,
  input logic              bus_resp_valid,
  input logic              bus_resp_err
);
  logic              outstanding_q;
  logic [LANE_W-1:0] size_mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              outstanding_q <= 1'b0;
    else if (bus_valid)      outstanding_q <= 1'b1;
    else if (bus_resp_valid) outstanding_q <= 1'b0;
  end

  assign size_mask = LANE_W'((1 << bus_size) - 1);

  assert_perm_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |-> perm_ok);

  assert_one_outstanding_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |-> !outstanding_q);

  assert_natural_align_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |-> ((bus_addr_lo & size_mask) == '0));

  assert_err_abort_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_resp_valid && bus_resp_err) |=> (done_valid && done_fault && !bus_valid));

  assert_zero_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && (req_len == '0)) |=> (done_valid && done_fault));

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |=> !done_valid);

  assert_busy_not_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done_valid || bus_valid) |-> !req_ready);
endmodule

bind mmio_split_unit mmio_split_chk #(
  .LEN_W(LEN_W), .LANE_W(LANE_W), .SIZE_W(SIZE_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_len(req_len), .done_valid(done_valid), .done_fault(done_fault),
  .perm_ok(perm_ok), .bus_valid(bus_valid),
  .bus_addr_lo(bus_addr[LANE_W-1:0]), .bus_size(bus_size),
  .bus_resp_valid(bus_resp_valid), .bus_resp_err(bus_resp_err)
);

// File: tb/mmio_split_unit_tb_top.sv
`timescale 1ns/1ps
module mmio_split_unit_tb_top;
  localparam int ADDR_W = 32;
  localparam int DATA_W = 64;

  logic              clk;
  logic              rst_n;
  logic              req_valid, req_ready, req_write;
  logic [ADDR_W-1:0] req_addr;
  logic [3:0]        req_len;
  logic [DATA_W-1:0] req_wdata;
  logic              done_valid, done_fault;
  logic [DATA_W-1:0] done_rdata;
  logic [ADDR_W-1:0] perm_addr;
  logic              perm_write, perm_ok;
  logic              bus_valid, bus_write;
  logic [ADDR_W-1:0] bus_addr;
  logic [1:0]        bus_size;
  logic [DATA_W-1:0] bus_wdata, bus_rdata;
  logic              bus_resp_valid, bus_resp_err;

  logic [7:0]        mem [256];
  logic              deny_en, err_en;
  logic [ADDR_W-1:0] deny_addr, err_addr;
  int                n_checks = 0;
  int                n_fail   = 0;
  bit                finished = 0;

  mmio_split_unit dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_len(req_len), .req_write(req_write), .req_wdata(req_wdata),
    .done_valid(done_valid), .done_fault(done_fault), .done_rdata(done_rdata),
    .perm_addr(perm_addr), .perm_write(perm_write), .perm_ok(perm_ok),
    .bus_valid(bus_valid), .bus_addr(bus_addr), .bus_size(bus_size),
    .bus_write(bus_write), .bus_wdata(bus_wdata),
    .bus_resp_valid(bus_resp_valid), .bus_resp_err(bus_resp_err),
    .bus_rdata(bus_rdata)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // permission model: one denied address, same for both directions
  assign perm_ok = !(deny_en && (perm_addr == deny_addr));

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  // bus responder: answers each transfer after 1..3 cycles
  initial begin
    logic [ADDR_W-1:0] a;
    logic [1:0]        sz;
    logic              wr;
    logic [DATA_W-1:0] wd;
    int                pend, wait_n, nresp;
    bus_resp_valid = 1'b0;
    bus_resp_err   = 1'b0;
    bus_rdata      = '0;
    pend = 0; wait_n = 0; nresp = 0;
    forever begin
      @(negedge clk);
      bus_resp_valid = 1'b0;
      bus_resp_err   = 1'b0;
      if (pend != 0) begin
        if (wait_n == 1) begin
          pend = 0;
          bus_resp_valid = 1'b1;
          bus_resp_err   = err_en && (a == err_addr);
          for (int k = 0; k < 8; k++) bus_rdata[8*k +: 8] = mem[8'(a + ADDR_W'(k))];
          if (wr && !bus_resp_err) begin
            for (int k = 0; k < (1 << sz); k++) mem[8'(a + ADDR_W'(k))] = wd[8*k +: 8];
          end
        end else begin
          wait_n--;
        end
      end else if (rst_n && bus_valid) begin
        a = bus_addr; sz = bus_size; wr = bus_write; wd = bus_wdata;
        pend = 1; wait_n = 1 + (nresp % 3); nresp++;
      end
    end
  end

  // one request against the behavioural reference
  task automatic run(input logic [31:0] addr, input int len, input bit wr,
                     input logic [63:0] wd, input string rq);
    logic [31:0] ea[$];
    logic [1:0]  es[$];
    logic [63:0] ew[$];
    bit          efault, bad, got;
    logic [63:0] erd;
    logic [31:0] x;
    efault = 0; got = 0; erd = '0;
    bad = (len == 0) || (len > 8);
    if (bad) begin
      efault = 1;
    end else if (((len & (len - 1)) == 0) && ((addr & 32'(len - 1)) == 0)) begin
      if (deny_en && addr == deny_addr) efault = 1;
      else begin
        ea.push_back(addr);
        es.push_back(len == 8 ? 2'd3 : len == 4 ? 2'd2 : len == 2 ? 2'd1 : 2'd0);
        ew.push_back(wd);
        if (err_en && addr == err_addr) efault = 1;
        else for (int i = 0; i < len; i++) erd[8*i +: 8] = mem[8'(addr + 32'(i))];
      end
    end else begin
      for (int i = 0; i < len; i++) begin
        x = addr + 32'(i);
        if (deny_en && x == deny_addr) begin efault = 1; break; end
        ea.push_back(x); es.push_back(2'd0); ew.push_back({56'd0, wd[8*i +: 8]});
        if (err_en && x == err_addr) begin efault = 1; break; end
        erd[8*i +: 8] = mem[8'(x)];
      end
    end

    @(negedge clk);
    chk(req_ready == 1'b1, "R9", "idle ready", 64'(req_ready), 64'd1);
    req_valid = 1'b1; req_addr = addr; req_len = 4'(len);
    req_write = wr; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    for (int c = 0; c < 100; c++) begin
      if (bus_valid) begin
        if (ea.size() == 0) begin
          chk(0, rq, "unexpected transfer", 64'(bus_addr), 64'd0);
        end else begin
          chk(bus_addr == ea[0], rq, "transfer address", 64'(bus_addr), 64'(ea[0]));
          chk(bus_size == es[0], rq, "transfer size", 64'(bus_size), 64'(es[0]));
          chk(bus_write == wr, "R10", "transfer direction", 64'(bus_write), 64'(wr));
          if (wr) chk(bus_wdata == ew[0], rq, "transfer data", bus_wdata, ew[0]);
          chk(perm_addr == ea[0], "R4", "permission address", 64'(perm_addr), 64'(ea[0]));
          void'(ea.pop_front()); void'(es.pop_front()); void'(ew.pop_front());
        end
      end
      if (done_valid) begin
        got = 1;
        chk(done_fault == efault, rq, "fault flag", 64'(done_fault), 64'(efault));
        if (!efault && !wr) chk(done_rdata == erd, "R8", "load data", done_rdata, erd);
        chk(ea.size() == 0, rq, "missing transfers", 64'(ea.size()), 64'd0);
        chk(req_ready == 1'b0, "R9", "busy while done", 64'(req_ready), 64'd0);
        if (bad) chk(c == 0, "R7", "reject latency", 64'(c), 64'd0);
        break;
      end
      @(negedge clk);
    end
    if (!got) chk(0, rq, "no completion", 64'd0, 64'd1);
    @(negedge clk);
    chk(done_valid == 1'b0, "R10", "done single pulse", 64'(done_valid), 64'd0);
  endtask

  initial begin
    logic [7:0] old93, oldb1;
    for (int i = 0; i < 256; i++) mem[i] = 8'(i * 7 + 3);
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_len = '0;
    req_write = 1'b0; req_wdata = '0;
    deny_en = 1'b0; err_en = 1'b0; deny_addr = '0; err_addr = '0;
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1 && bus_valid == 1'b0 && done_valid == 1'b0, "R1",
        "state in reset", {61'd0, req_ready, bus_valid, done_valid}, 64'd4);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(req_ready == 1'b1 && bus_valid == 1'b0 && done_valid == 1'b0, "R1",
        "state after reset", {61'd0, req_ready, bus_valid, done_valid}, 64'd4);

    // whole transfers of every size
    run(32'h40, 8, 0, '0, "R2");
    run(32'h44, 4, 0, '0, "R2");
    run(32'h12, 2, 0, '0, "R2");
    run(32'h13, 1, 0, '0, "R2");
    run(32'h20, 4, 1, 64'h1122_3344_A1B2_C3D4, "R2");
    chk(mem[8'h20] == 8'hD4 && mem[8'h23] == 8'hA1, "R2", "whole store bytes",
        {mem[8'h23], mem[8'h20]}, 64'hA1D4);
    run(32'h20, 4, 0, '0, "R2");

    // split transfers
    run(32'h30, 3, 0, '0, "R3");
    run(32'h31, 8, 0, '0, "R3");
    run(32'h33, 2, 0, '0, "R3");
    run(32'h22, 4, 0, '0, "R3");
    run(32'h50, 5, 0, '0, "R3");
    run(32'h61, 7, 0, '0, "R3");
    run(32'h71, 6, 1, 64'h0F0E_6655_4433_2211, "R3");
    chk(mem[8'h71] == 8'h11 && mem[8'h76] == 8'h66, "R3", "split store bytes",
        {mem[8'h76], mem[8'h71]}, 64'h6611);
    run(32'h70, 8, 0, '0, "R3");

    // rejected lengths
    run(32'h10, 0, 0, '0, "R7");
    run(32'h10, 9, 1, 64'hFFFF, "R7");
    run(32'h10, 15, 0, '0, "R7");

    // permission refusals
    deny_en = 1'b1; deny_addr = 32'h82;
    run(32'h80, 4, 0, '0, "R4");
    deny_addr = 32'h88;
    run(32'h88, 8, 0, '0, "R4");
    deny_addr = 32'hB1;
    oldb1 = mem[8'hB1];
    run(32'hB1, 3, 1, 64'h00_7766_55, "R4");
    chk(mem[8'hB1] == oldb1, "R4", "refused store untouched", 64'(mem[8'hB1]), 64'(oldb1));
    deny_en = 1'b0;

    // bus errors and no rollback
    err_en = 1'b1; err_addr = 32'h93;
    old93 = mem[8'h93];
    run(32'h91, 5, 1, 64'h00_EEDD_CCBB_AA, "R5");
    chk(mem[8'h91] == 8'hAA && mem[8'h92] == 8'hBB, "R6", "bytes before error kept",
        {mem[8'h92], mem[8'h91]}, 64'hBBAA);
    chk(mem[8'h93] == old93 && mem[8'h94] != 8'hDD, "R6", "nothing after error",
        64'(mem[8'h93]), 64'(old93));
    err_addr = 32'hA0;
    run(32'hA0, 2, 0, '0, "R5");
    err_en = 1'b0;
    run(32'h90, 8, 0, '0, "R6");

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule